// File: doc/BRIEF.md
# Burst Bus Cycle Sequencer

This block is the processor-side sequencer for a 32-bit local bus. An internal agent hands it one request at a time: a word address, a 3-bit cycle kind, a 4-bit byte mask and a burst flag. The sequencer turns that request into one or more bus cycles. For each cycle it drives an address strobe, the address, three cycle definition bits, active-low byte lane enables and a last-transfer indicator. It then waits for the device to end the transfer on either the single-transfer ready input or the burst ready input.

Narrow devices report an 8-bit or 16-bit port width on two active-low size inputs. When they do, the sequencer starts a fresh cycle for the bytes that are still pending and repeats this until every enabled byte has moved. Cacheable fills run as a four-beat burst under a single strobe. Special cycles (shutdown, flush, halt, write-back) use a fixed definition code. The byte enables select which special cycle it is, and the address is driven to zero. A one-clock completion pulse marks the end of the whole transaction.

Top module: `bus_cycle_seq`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in progress, and a request is taken only then. While a transaction runs, `req_valid` has no effect on the bus outputs. After reset the bus is idle: `strobe_n`=1, `last_n`=1, `lane_en_n`=4'b1111, `txn_done`=0.
- R2: `strobe_n` is low for exactly the first clock of every bus cycle. The address, definition bits and lane enables become valid in that same clock and hold until the cycle ends.
- R3: The definition bits {`def_mem`,`def_data`,`def_write`} carry `req_kind` unchanged. The codes are: 110 memory read, 111 memory write, 100 code read, 101 reserved, 010 I/O read, 011 I/O write, 000 interrupt acknowledge, 001 special cycle.
- R4: A request of kind 001 is a special cycle. It drives the address as all zeros, drives `lane_en_n` = ~`req_bytes` (0111 write-back, 1011 halt, 1101 flush, 1110 shutdown) and runs as one cycle whatever size the device reports.
- R5: Both ready inputs are ignored while idle and in the first clock of a cycle. They are sampled from the second clock onward.
- R6: A non-burst request keeps `last_n` low for the whole cycle. The cycle ends on either ready input being low.
- R7: A burst request drives `lane_en_n`=0000 and moves four transfers under one strobe, each ended by `burst_rdy_n` low. `last_n` is low only during the fourth transfer.
- R8: If `single_rdy_n` is low during a burst (alone or together with `burst_rdy_n`), the burst ready is ignored and the burst ends after that transfer.
- R9: The size inputs are registered every clock. The value registered one clock before the completing ready sets the width of that cycle: both high is 32-bit, `narrow16_n` low is 16-bit, and `narrow8_n` low is 8-bit, which wins over 16-bit. Bursts always move 32 bits.
- R10: Lane i of `lane_en_n` covers data bits 8i+7..8i. On a 16-bit completion the lanes of the half (lanes 1:0, else lanes 3:2) that holds the lowest pending lane are moved. On an 8-bit completion only the lowest pending lane is moved. If bytes remain, a new cycle to the same address starts in the clock after the ready, and `lane_en_n` shows only the remaining lanes.
- R11: `txn_done` pulses for one clock, in the clock after the ready that finishes the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | ADDR_W-2 | Word address of the request |
| req_kind | input | 3 | Cycle kind code (R3) |
| req_bytes | input | 4 | Byte mask, active high, lane i = bits 8i+7..8i |
| req_burst | input | 1 | Four-beat cacheable fill |
| strobe_n | output | 1 | Address strobe, active low |
| addr | output | ADDR_W-2 | Bus word address |
| def_mem | output | 1 | Memory (1) or I/O (0) |
| def_data | output | 1 | Data (1) or control (0) |
| def_write | output | 1 | Write (1) or read (0) |
| lane_en_n | output | 4 | Byte lane enables, active low |
| last_n | output | 1 | Next ready ends the transfer, active low |
| single_rdy_n | input | 1 | Non-burst ready, active low |
| burst_rdy_n | input | 1 | Burst ready, active low |
| narrow8_n | input | 1 | Device is 8 bits wide, active low |
| narrow16_n | input | 1 | Device is 16 bits wide, active low |
| txn_done | output | 1 | Whole transaction complete, one-clock pulse |

## Verification
A request taken at edge k puts the strobe on the bus right after k. A ready is honoured only at edge k+2 or later. When a ready is seen at edge e, the completion pulse or the strobe of the next split cycle is due just after e. The size used at edge e is whatever was driven during the clock before the ready clock. The bench drives inputs on falling edges and samples on the next falling edge after each rising edge. It drives ready pulses during the strobe clock to show they are ignored. It changes the size inputs during the ready clock itself, so a width taken from the wrong clock shows up as a wrong lane count. Expected lane masks and beat counts come from bench functions written from R9 and R10.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int BUS_LANES = 4;

    typedef enum logic [2:0] {
        CYC_INTA    = 3'b000,
        CYC_SPECIAL = 3'b001,
        CYC_IO_RD   = 3'b010,
        CYC_IO_WR   = 3'b011,
        CYC_CODE_RD = 3'b100,
        CYC_RSVD    = 3'b101,
        CYC_MEM_RD  = 3'b110,
        CYC_MEM_WR  = 3'b111
    } cyc_kind_e;

    typedef enum logic [1:0] {
        WID_32 = 2'd0,
        WID_16 = 2'd1,
        WID_8  = 2'd2
    } bus_width_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    typedef struct packed {
        cyc_kind_e              kind;
        logic [BUS_LANES-1:0]   bytes;
        logic                   burst;
    } cyc_info_t;

    // 8-bit sizing wins over 16-bit when both are reported
    function automatic bus_width_e decode_width(logic n8, logic n16);
        if (!n8)       return WID_8;
        else if (!n16) return WID_16;
        else           return WID_32;
    endfunction

    // lanes transferred by one completion at the given width
    function automatic logic [BUS_LANES-1:0] lanes_moved(
        logic [BUS_LANES-1:0] pend, bus_width_e wid);
        logic [BUS_LANES-1:0] res;
        case (wid)
            WID_16:  res = (pend[1:0] != 2'b00) ? (pend & 4'b0011)
                                                : (pend & 4'b1100);
            WID_8:   res = pend & (~pend + 4'd1);
            default: res = pend;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/bus_size_sampler.sv
module bus_size_sampler
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       narrow8_n,
    input  logic       narrow16_n,
    output bus_width_e width_q
);
    always_ff @(posedge clk) begin
        if (rst) width_q <= WID_32;
        else     width_q <= decode_width(narrow8_n, narrow16_n);
    end
endmodule

// File: rtl/lane_split.sv
module lane_split
    import bus_seq_pkg::*;
(
    input  logic [BUS_LANES-1:0] pend,
    input  bus_width_e           width,
    input  logic                 special,
    output logic [BUS_LANES-1:0] left
);
    always_comb begin
        if (special) left = '0;
        else         left = pend & ~lanes_moved(pend, width);
    end
endmodule

// File: rtl/seq_core.sv
module seq_core
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-3:0]    req_addr,
    input  logic [2:0]           req_kind,
    input  logic [BUS_LANES-1:0] req_bytes,
    input  logic                 req_burst,
    input  logic                 single_rdy_n,
    input  logic                 burst_rdy_n,
    input  logic [BUS_LANES-1:0] left_i,
    output seq_state_e           state_o,
    output cyc_info_t            info_o,
    output logic [ADDR_W-3:0]    addr_q,
    output logic                 beat_last,
    output logic                 done_o
);
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);

    seq_state_e        state_q;
    cyc_info_t         info_q;
    logic [BEAT_W-1:0] beat_q;
    logic              rdy_s, rdy_b;

    assign rdy_s     = !single_rdy_n;
    assign rdy_b     = !burst_rdy_n;
    assign beat_last = (beat_q == LAST_BEAT);
    assign state_o   = state_q;
    assign info_o    = info_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            info_q  <= '{kind: CYC_INTA, bytes: '0, burst: 1'b0};
            addr_q  <= '0;
            beat_q  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        info_q.kind  <= cyc_kind_e'(req_kind);
                        info_q.bytes <= req_burst ? '1 : req_bytes;
                        info_q.burst <= req_burst;
                        addr_q       <= req_addr;
                        beat_q       <= '0;
                        state_q      <= ST_ADDR;
                    end
                end
                ST_ADDR: state_q <= ST_DATA;
                ST_DATA: begin
                    if (info_q.burst) begin
                        if (rdy_s || (rdy_b && beat_last)) begin
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (rdy_b) begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end else if (rdy_s || rdy_b) begin
                        info_q.bytes <= left_i;
                        if (left_i == '0) begin
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_ADDR;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-3:0] req_addr,
    input  logic [2:0]        req_kind,
    input  logic [3:0]        req_bytes,
    input  logic              req_burst,
    output logic              strobe_n,
    output logic [ADDR_W-3:0] addr,
    output logic              def_mem,
    output logic              def_data,
    output logic              def_write,
    output logic [3:0]        lane_en_n,
    output logic              last_n,
    input  logic              single_rdy_n,
    input  logic              burst_rdy_n,
    input  logic              narrow8_n,
    input  logic              narrow16_n,
    output logic              txn_done
);
    seq_state_e           state;
    cyc_info_t            info;
    logic [ADDR_W-3:0]    addr_q;
    logic                 beat_last;
    bus_width_e           width;
    logic [BUS_LANES-1:0] left;
    logic                 active, special;

    bus_size_sampler u_size (
        .clk        (clk),
        .rst        (rst),
        .narrow8_n  (narrow8_n),
        .narrow16_n (narrow16_n),
        .width_q    (width)
    );

    lane_split u_split (
        .pend    (info.bytes),
        .width   (width),
        .special (special),
        .left    (left)
    );

    seq_core #(.ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS)) u_core (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_kind     (req_kind),
        .req_bytes    (req_bytes),
        .req_burst    (req_burst),
        .single_rdy_n (single_rdy_n),
        .burst_rdy_n  (burst_rdy_n),
        .left_i       (left),
        .state_o      (state),
        .info_o       (info),
        .addr_q       (addr_q),
        .beat_last    (beat_last),
        .done_o       (txn_done)
    );

    assign active    = (state != ST_IDLE);
    assign special   = (info.kind == CYC_SPECIAL);
    assign req_ready = !active;
    assign strobe_n  = !(state == ST_ADDR);
    assign addr      = (active && !special) ? addr_q : '0;
    assign {def_mem, def_data, def_write} = active ? info.kind : 3'b000;
    assign lane_en_n = active ? ~info.bytes : 4'hF;
    assign last_n    = !(active && (!info.burst || beat_last));
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              strobe_n,
    input logic [ADDR_W-3:0] addr,
    input logic              def_mem,
    input logic              def_data,
    input logic              def_write,
    input logic [3:0]        lane_en_n,
    input logic              last_n,
    input logic              single_rdy_n,
    input logic              burst_rdy_n,
    input logic              txn_done
);
    // R2
    strobe_single_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |=> strobe_n);
    // R2
    cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |=> ($stable(lane_en_n) && $stable(addr)
                       && $stable({def_mem, def_data, def_write})));
    // R5
    no_first_clk_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |=> !txn_done);
    // R4
    special_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && {def_mem, def_data, def_write} == 3'b001) |-> (addr == '0));
    // R11
    done_follows_ready_chk: assert property (@(posedge clk) disable iff (rst)
        txn_done |-> $past(!single_rdy_n || !burst_rdy_n));
    // R8
    done_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        txn_done |-> $past(!last_n || !single_rdy_n));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        txn_done |=> !txn_done);
    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (strobe_n && last_n && lane_en_n == 4'hF));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .strobe_n     (strobe_n),
    .addr         (addr),
    .def_mem      (def_mem),
    .def_data     (def_data),
    .def_write    (def_write),
    .lane_en_n    (lane_en_n),
    .last_n       (last_n),
    .single_rdy_n (single_rdy_n),
    .burst_rdy_n  (burst_rdy_n),
    .txn_done     (txn_done)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_ready;
    logic [AW-3:0] req_addr = '0;
    logic [2:0]    req_kind = 3'b000;
    logic [3:0]    req_bytes = 4'h0;
    logic          req_burst = 1'b0;
    logic          strobe_n, def_mem, def_data, def_write, last_n, txn_done;
    logic [AW-3:0] addr;
    logic [3:0]    lane_en_n;
    logic          single_rdy_n = 1'b1, burst_rdy_n = 1'b1;
    logic          narrow8_n = 1'b1, narrow16_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bus_cycle_seq #(.ADDR_W(AW), .BURST_BEATS(4)) u_bus_cycle_seq (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // width code: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = both low (8-bit)
    task automatic set_size(input int w);
        narrow8_n  = !(w >= 2);
        narrow16_n = !(w == 1 || w == 3);
    endtask

    function automatic logic [3:0] exp_left(input logic [3:0] rem, input int w);
        if (w == 0) return 4'h0;
        if (w == 1) return (rem[0] | rem[1]) ? {rem[3:2], 2'b00} : 4'h0;
        return rem & (rem - 4'd1);
    endfunction

    // single (non-burst) transaction; force_w < 0 picks sizes at random
    task automatic run_single(input logic [2:0] kind, input logic [AW-3:0] a,
                              input logic [3:0] mask, input bit use_b,
                              input int force_w, input bit poke);
        logic [3:0]    rem;
        logic [AW-3:0] ea;
        int            w, nw;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_kind = kind;
        req_bytes = mask; req_burst = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        rem = mask;
        ea  = (kind == 3'b001) ? '0 : a;
        forever begin
            chk(strobe_n === 1'b0, "R2 strobe in first clock", strobe_n, 0);
            chk(lane_en_n === ~rem, "R10 lane enables", lane_en_n, ~rem);
            chk(addr === ea, "R4 R10 address", addr, ea);
            chk({def_mem, def_data, def_write} === kind, "R3 definition",
                {def_mem, def_data, def_write}, kind);
            chk(last_n === 1'b0, "R6 last on single", last_n, 0);
            w = (force_w >= 0) ? force_w : int'($urandom % 4);
            set_size(w);
            single_rdy_n = $urandom % 2;
            burst_rdy_n  = $urandom % 2;
            @(negedge clk);
            single_rdy_n = 1'b1; burst_rdy_n = 1'b1;
            chk(strobe_n === 1'b1 && txn_done === 1'b0,
                "R5 ready ignored in first clock", {strobe_n, txn_done}, 2'b10);
            if (poke) begin
                req_valid = 1'b1; req_addr = ~a; req_kind = 3'b110;
            end
            repeat ($urandom % 3) begin
                @(negedge clk);
                chk(strobe_n === 1'b1 && txn_done === 1'b0 && addr === ea,
                    "R1 R5 waiting", {strobe_n, txn_done}, 2'b10);
            end
            req_valid = 1'b0;
            if (use_b) burst_rdy_n = 1'b0; else single_rdy_n = 1'b0;
            nw = int'($urandom % 4);
            set_size(nw);
            @(negedge clk);
            single_rdy_n = 1'b1; burst_rdy_n = 1'b1;
            rem = (kind == 3'b001) ? 4'h0 : exp_left(rem, w);
            if (rem == 4'h0) begin
                chk(txn_done === 1'b1 && strobe_n === 1'b1, "R11 R9 done after final ready",
                    {txn_done, strobe_n}, 2'b11);
                @(negedge clk);
                chk(txn_done === 1'b0 && strobe_n === 1'b1 && lane_en_n === 4'hF,
                    "R1 R11 idle after done", {txn_done, strobe_n, lane_en_n}, 6'b011111);
                break;
            end
            chk(txn_done === 1'b0, "R9 R10 more cycles pending", txn_done, 0);
        end
    endtask

    // burst transaction; abort_at in 0..3 drives single ready on that beat
    task automatic run_burst(input logic [2:0] kind, input logic [AW-3:0] a,
                             input int abort_at);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = kind;
        req_bytes = 4'h3; req_burst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_burst = 1'b0;
        chk(strobe_n === 1'b0 && lane_en_n === 4'h0, "R7 burst start",
            {strobe_n, lane_en_n}, 5'b00000);
        chk(last_n === 1'b1, "R7 last high on first beat", last_n, 1);
        set_size(int'($urandom % 4));
        single_rdy_n = 1'b0; burst_rdy_n = 1'b0;
        @(negedge clk);
        single_rdy_n = 1'b1; burst_rdy_n = 1'b1;
        chk(txn_done === 1'b0, "R5 burst ready ignored in first clock", txn_done, 0);
        for (int beat = 0; beat < 4; beat++) begin
            chk(last_n === (beat != 3), "R7 last on fourth beat", last_n, (beat != 3));
            chk(strobe_n === 1'b1, "R7 one strobe per burst", strobe_n, 1);
            repeat ($urandom % 2) @(negedge clk);
            burst_rdy_n = 1'b0;
            if (beat == abort_at) single_rdy_n = 1'b0;
            @(negedge clk);
            single_rdy_n = 1'b1; burst_rdy_n = 1'b1;
            if (beat == abort_at || beat == 3) begin
                chk(txn_done === 1'b1, "R8 R7 burst done", txn_done, 1);
                break;
            end
            chk(txn_done === 1'b0, "R7 burst continues", txn_done, 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(strobe_n === 1'b1 && last_n === 1'b1 && lane_en_n === 4'hF
            && txn_done === 1'b0 && req_ready === 1'b1, "R1 reset state",
            {strobe_n, last_n, lane_en_n, txn_done, req_ready}, 8'hFD);
        // directed: full width, both ready kinds
        run_single(3'b110, 30'h123, 4'hF, 1'b0, 0, 1'b0);
        run_single(3'b111, 30'h124, 4'hF, 1'b1, 0, 1'b0);
        // directed narrow splits (R9 R10)
        run_single(3'b110, 30'h200, 4'hF, 1'b0, 2, 1'b0);
        run_single(3'b111, 30'h201, 4'hF, 1'b0, 3, 1'b0);
        run_single(3'b010, 30'h202, 4'h6, 1'b0, 1, 1'b0);
        run_single(3'b011, 30'h203, 4'hC, 1'b0, 1, 1'b0);
        // requests offered mid-transaction are ignored (R1)
        run_single(3'b100, 30'h300, 4'hF, 1'b0, 1, 1'b1);
        // special cycles under 8-bit sizing (R4)
        run_single(3'b001, 30'h3FF, 4'h1, 1'b0, 2, 1'b0);
        run_single(3'b001, 30'h3FF, 4'h2, 1'b1, 2, 1'b0);
        run_single(3'b001, 30'h3FF, 4'h4, 1'b0, 1, 1'b0);
        run_single(3'b001, 30'h3FF, 4'h8, 1'b0, 3, 1'b0);
        // bursts: full and aborted (R7 R8)
        run_burst(3'b100, 30'h400, 4);
        run_burst(3'b110, 30'h404, 1);
        run_burst(3'b110, 30'h408, 3);
        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [2:0] kinds [6] = '{3'b000, 3'b010, 3'b011, 3'b100, 3'b110, 3'b111};
            logic [3:0] m;
            m = 4'($urandom % 15) + 4'd1;
            if ($urandom % 4 == 0)
                run_burst(3'b110, 30'($urandom), int'($urandom % 5));
            else
                run_single(kinds[$urandom % 6], 30'($urandom), m,
                           1'($urandom % 2), -1, 1'($urandom % 2));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule